// File: doc/BRIEF.md
# Dual-Rail Ternary Cut-Consistency Checker

This block evaluates one assignment of a small gate network that was cyclic and has been made acyclic by cutting some of its wires. Each signal carries a ternary value (0, 1 or undefined) on two rails. Every gate is a dual-rail AND, OR, NAND, NOR or NOT. Each cut wire is replaced by a pair of free dummy bits, and those bits feed the gates downstream of the cut. A configuration table describes the network: an operation and two source selects for each of eight gates, plus a list of cut slots. Each cut slot names the gate whose output is the cut location and has an enable bit.

For every cut, the block reports two things. The first is whether the dummy pair agrees with the value the network computes at the cut location, where two undefined values count as agreeing. The second is whether the dummy pair is undefined. A single witness bit combines these. It is set when every cut is self-consistent and at least one cut carries an undefined value, which means this assignment shows that the original loop does not settle to definite values. A search engine outside the block drives one assignment per clock and reads the registered result one cycle later.

Top module: `tern_cut_checker`

## Requirements
- R1: Ternary values are carried as a rail pair {rail1, rail0}. Equal rails are a definite value (00 is 0, 11 is 1) and unequal rails are undefined. Primary input bit p drives both rails of its signal, so it is always 00 or 11.
- R2: Op code 0 is AND and op code 1 is OR. AND gives 0 if either input is 0, gives 1 if both inputs are 1, and is undefined otherwise. OR gives 1 if either input is 1, gives 0 if both inputs are 0, and is undefined otherwise.
- R3: Op code 2 is NAND and op code 3 is NOR, each formed by complementing both rails of AND or OR. Op codes 4 to 7 are NOT of input A, which complements each rail, so an undefined input stays undefined.
- R4: A source select value s below 4 picks primary input s. A value from 4 to 7 picks the dummy pair of cut s-4, with rail0 taken from the dummy_r0 bit and rail1 from the dummy_r1 bit. A value from 8 to 15 picks gate s-8 only if that gate has a lower index than the reading gate. Any other select reads undefined.
- R5: For an enabled cut i, consist_o[i] is 1 exactly when the dummy pair and the output of the gate named in cut_gate field i hold the same ternary value. Two undefined values match even when their rail patterns differ.
- R6: For an enabled cut i, undef_o[i] is the XOR of its two dummy bits.
- R7: witness_o is 1 exactly when all bits of consist_o are 1 and at least one bit of undef_o is 1.
- R8: A disabled cut slot reads consist_o[i]=1 and undef_o[i]=0 whatever its dummies are. With every slot disabled, the witness is 0.
- R9: All outputs are registered and reflect the inputs of the previous clock. A synchronous active-low reset clears every output to 0.
- R10: Consider a two-NAND ring in which gate 0 reads input 0 and the dummy of cut 1, gate 1 reads input 1 and the dummy of cut 0, and the cuts sit at gates 0 and 1. With both inputs at 1 and both dummy pairs undefined, every consist and undef bit is 1 and the witness is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pi_i | input | 4 | Binary primary inputs |
| dum_r0_i | input | 4 | Rail-0 dummy bit per cut |
| dum_r1_i | input | 4 | Rail-1 dummy bit per cut |
| gate_op_i | input | 24 | 3-bit op code per gate, gate g at bits [3g+2:3g] |
| gate_src_a_i | input | 32 | 4-bit source select A per gate |
| gate_src_b_i | input | 32 | 4-bit source select B per gate |
| cut_gate_i | input | 12 | 3-bit gate index per cut location |
| cut_en_i | input | 4 | Enable per cut slot |
| consist_o | output | 4 | Per-cut consistency result |
| undef_o | output | 4 | Per-cut undefined flag |
| witness_o | output | 1 | Invalid-loop witness |

## Verification
A two-NAND ring is driven in three ways. With both inputs at 1 and undefined dummies it must produce a witness. With one input at 0 and the settled definite dummies it is consistent but gives no witness. With definite dummies that disagree with the gates it is inconsistent. These three cases separate the agreement logic from the undefined logic. A sweep over every op code, with definite and both undefined rail patterns on one input and 0 and 1 on the other, probes each gate output through a cut against dummies of 0, 1 and undefined, which pins down each truth table. Self-referencing and forward-referencing selects, disabled slots with mismatched dummies, and random configurations are compared every cycle against a behavioural ternary model.

// File: rtl/tdr_pkg.sv
// Shared types and ternary helpers for the dual-rail cut checker.
// Assumes a rail pair is {rail1, rail0}; equal rails are definite.
package tdr_pkg;

    typedef logic [1:0] rail_t;

    localparam rail_t RAIL_ZERO  = 2'b00;
    localparam rail_t RAIL_ONE   = 2'b11;
    localparam rail_t RAIL_UNDEF = 2'b01;

    localparam logic [2:0] OP_AND  = 3'd0;
    localparam logic [2:0] OP_OR   = 3'd1;
    localparam logic [2:0] OP_NAND = 3'd2;
    localparam logic [2:0] OP_NOR  = 3'd3;

    // True when both rails agree (a definite 0 or 1).
    function automatic logic rail_defined(rail_t v);
        return v[0] == v[1];
    endfunction

    // Dual-rail AND: 0 dominates, 1 only when both are 1.
    function automatic rail_t rail_and(rail_t a, rail_t b);
        if (a == RAIL_ZERO || b == RAIL_ZERO) return RAIL_ZERO;
        if (a == RAIL_ONE && b == RAIL_ONE)   return RAIL_ONE;
        return RAIL_UNDEF;
    endfunction

    // Dual-rail OR: 1 dominates, 0 only when both are 0.
    function automatic rail_t rail_or(rail_t a, rail_t b);
        if (a == RAIL_ONE || b == RAIL_ONE)   return RAIL_ONE;
        if (a == RAIL_ZERO && b == RAIL_ZERO) return RAIL_ZERO;
        return RAIL_UNDEF;
    endfunction

endpackage

// File: rtl/tdr_gate.sv
// One dual-rail ternary gate. Op codes 0..3 select AND/OR/NAND/NOR;
// any higher code inverts input A and ignores B. Purely combinational.
module tdr_gate
    import tdr_pkg::*;
(
    input  logic [2:0] op_i,
    input  rail_t      a_i,
    input  rail_t      b_i,
    output rail_t      y_o
);

    // Evaluate the selected ternary operation on the two rail pairs.
    always_comb begin
        case (op_i)
            OP_AND:  y_o = rail_and(a_i, b_i);
            OP_OR:   y_o = rail_or(a_i, b_i);
            OP_NAND: y_o = ~rail_and(a_i, b_i);
            OP_NOR:  y_o = ~rail_or(a_i, b_i);
            default: y_o = ~a_i;
        endcase
    end

endmodule

// File: rtl/tdr_net.sv
// Feed-forward network of dual-rail gates. Leaves are the primary inputs
// (both rails tied to the bit) followed by the cut dummy pairs; gate g may
// read only gates of lower index, anything else reads as undefined. This
// keeps the evaluated structure acyclic whatever the configuration says.
module tdr_net
    import tdr_pkg::*;
#(
    parameter int NUM_PI    = 4,
    parameter int NUM_CUTS  = 4,
    parameter int NUM_GATES = 8,
    parameter int SRC_W     = 4
) (
    input  logic [NUM_PI-1:0]          pi_i,
    input  logic [NUM_CUTS-1:0]        dum_r0_i,
    input  logic [NUM_CUTS-1:0]        dum_r1_i,
    input  logic [NUM_GATES*3-1:0]     gate_op_i,
    input  logic [NUM_GATES*SRC_W-1:0] gate_src_a_i,
    input  logic [NUM_GATES*SRC_W-1:0] gate_src_b_i,
    output rail_t                      gate_y_o [NUM_GATES]
);

    localparam int NUM_LEAF = NUM_PI + NUM_CUTS;

    rail_t leaf [NUM_LEAF];

    generate
        for (genvar p = 0; p < NUM_PI; p++) begin : gen_pi_leaf
            assign leaf[p] = {pi_i[p], pi_i[p]};
        end
        for (genvar c = 0; c < NUM_CUTS; c++) begin : gen_cut_leaf
            assign leaf[NUM_PI+c] = {dum_r1_i[c], dum_r0_i[c]};
        end
    endgenerate

    // Resolve a source select for a gate whose index is 'lim'.
    function automatic rail_t resolve(logic [SRC_W-1:0] sel, int lim);
        rail_t v;
        v = RAIL_UNDEF;
        for (int s = 0; s < NUM_LEAF; s++) begin
            if (int'(sel) == s) v = leaf[s];
        end
        for (int k = 0; k < lim; k++) begin
            if (int'(sel) == NUM_LEAF + k) v = gate_y_o[k];
        end
        return v;
    endfunction

    generate
        for (genvar g = 0; g < NUM_GATES; g++) begin : gen_gate
            rail_t in_a;
            rail_t in_b;

            // Pick both operands from leaves or earlier gates.
            always_comb begin
                in_a = resolve(gate_src_a_i[g*SRC_W +: SRC_W], g);
                in_b = resolve(gate_src_b_i[g*SRC_W +: SRC_W], g);
            end

            tdr_gate u_gate (
                .op_i (gate_op_i[g*3 +: 3]),
                .a_i  (in_a),
                .b_i  (in_b),
                .y_o  (gate_y_o[g])
            );
        end
    endgenerate

endmodule

// File: rtl/tdr_cut_check.sv
// Per-cut checks: agreement between the dummy pair and the value computed
// at the cut location (undefined matches undefined), and the undefined
// flag of the dummies. A disabled slot reports match=1, undefined=0.
module tdr_cut_check
    import tdr_pkg::*;
(
    input  logic  en_i,
    input  logic  dum_r0_i,
    input  logic  dum_r1_i,
    input  rail_t comp_i,
    output logic  match_o,
    output logic  undef_o
);

    rail_t dum;
    assign dum = {dum_r1_i, dum_r0_i};

    // Compare ternary values and flag an undefined dummy pair.
    always_comb begin
        if (!en_i) begin
            match_o = 1'b1;
            undef_o = 1'b0;
        end else begin
            undef_o = dum_r0_i ^ dum_r1_i;
            if (rail_defined(dum)) begin
                match_o = rail_defined(comp_i) && (comp_i[0] == dum[0]);
            end else begin
                match_o = !rail_defined(comp_i);
            end
        end
    end

endmodule

// File: rtl/tern_cut_checker.sv
// Top of the dual-rail ternary cut-consistency checker. Evaluates one
// assignment of the cut network and registers the per-cut results and the
// witness. Assumes the configuration is stable during the evaluated cycle.
module tern_cut_checker
    import tdr_pkg::*;
#(
    parameter int NUM_PI    = 4,
    parameter int NUM_CUTS  = 4,
    parameter int NUM_GATES = 8,
    localparam int SRC_W    = $clog2(NUM_PI + NUM_CUTS + NUM_GATES),
    localparam int GIDX_W   = $clog2(NUM_GATES)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_PI-1:0]           pi_i,
    input  logic [NUM_CUTS-1:0]         dum_r0_i,
    input  logic [NUM_CUTS-1:0]         dum_r1_i,
    input  logic [NUM_GATES*3-1:0]      gate_op_i,
    input  logic [NUM_GATES*SRC_W-1:0]  gate_src_a_i,
    input  logic [NUM_GATES*SRC_W-1:0]  gate_src_b_i,
    input  logic [NUM_CUTS*GIDX_W-1:0]  cut_gate_i,
    input  logic [NUM_CUTS-1:0]         cut_en_i,
    output logic [NUM_CUTS-1:0]         consist_o,
    output logic [NUM_CUTS-1:0]         undef_o,
    output logic                        witness_o
);

    rail_t               gate_y [NUM_GATES];
    logic [NUM_CUTS-1:0] match_d;
    logic [NUM_CUTS-1:0] undef_d;
    logic                witness_d;

    tdr_net #(
        .NUM_PI    (NUM_PI),
        .NUM_CUTS  (NUM_CUTS),
        .NUM_GATES (NUM_GATES),
        .SRC_W     (SRC_W)
    ) u_net (
        .pi_i         (pi_i),
        .dum_r0_i     (dum_r0_i),
        .dum_r1_i     (dum_r1_i),
        .gate_op_i    (gate_op_i),
        .gate_src_a_i (gate_src_a_i),
        .gate_src_b_i (gate_src_b_i),
        .gate_y_o     (gate_y)
    );

    generate
        for (genvar c = 0; c < NUM_CUTS; c++) begin : gen_cut
            rail_t comp;

            // Fetch the computed value at this cut's location.
            always_comb begin
                comp = RAIL_UNDEF;
                for (int k = 0; k < NUM_GATES; k++) begin
                    if (int'(cut_gate_i[c*GIDX_W +: GIDX_W]) == k) comp = gate_y[k];
                end
            end

            tdr_cut_check u_chk (
                .en_i     (cut_en_i[c]),
                .dum_r0_i (dum_r0_i[c]),
                .dum_r1_i (dum_r1_i[c]),
                .comp_i   (comp),
                .match_o  (match_d[c]),
                .undef_o  (undef_d[c])
            );

            // R8: a disabled slot reads consistent and defined next cycle.
            p_masked_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
                !cut_en_i[c] |=> (consist_o[c] && !undef_o[c]));
        end
    endgenerate

    // Witness needs all cuts consistent and some cut undefined.
    assign witness_d = (&match_d) && (|undef_d);

    // Register results; synchronous active-low reset clears them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            consist_o <= '0;
            undef_o   <= '0;
            witness_o <= 1'b0;
        end else begin
            consist_o <= match_d;
            undef_o   <= undef_d;
            witness_o <= witness_d;
        end
    end

    // R6: undefined flags follow the enabled dummy XOR one cycle later.
    p_undef_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (undef_o == $past(cut_en_i & (dum_r0_i ^ dum_r1_i))));

    // R7: with every dummy pair definite no witness can follow.
    p_no_undef_no_witness_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((dum_r0_i ^ dum_r1_i) == '0) |=> !witness_o);

    // R7: a witness is only ever raised alongside full consistency.
    p_witness_consistent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        witness_o |-> ((&consist_o) && (|undef_o)));

endmodule

// File: tb/tern_cut_checker_bench.sv
module tern_cut_checker_bench;

    localparam int NP = 4;
    localparam int NC = 4;
    localparam int NG = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [NP-1:0] pi;
    logic [NC-1:0] d0, d1, cen;
    logic [2:0]    op [NG];
    logic [3:0]    sa [NG];
    logic [3:0]    sb [NG];
    logic [2:0]    cg [NC];

    logic [NG*3-1:0] op_bus;
    logic [NG*4-1:0] sa_bus, sb_bus;
    logic [NC*3-1:0] cg_bus;
    logic [NC-1:0]   cons, und;
    logic            wit;

    always_comb begin
        for (int g = 0; g < NG; g++) begin
            op_bus[g*3 +: 3] = op[g];
            sa_bus[g*4 +: 4] = sa[g];
            sb_bus[g*4 +: 4] = sb[g];
        end
        for (int c = 0; c < NC; c++) cg_bus[c*3 +: 3] = cg[c];
    end

    tern_cut_checker u_tern_cut_checker (
        .clk(clk), .rst_n(rst_n), .pi_i(pi), .dum_r0_i(d0), .dum_r1_i(d1),
        .gate_op_i(op_bus), .gate_src_a_i(sa_bus), .gate_src_b_i(sb_bus),
        .cut_gate_i(cg_bus), .cut_en_i(cen),
        .consist_o(cons), .undef_o(und), .witness_o(wit)
    );

    int checks = 0;
    int failures = 0;

    // Ternary model: 0, 1, 2 = undefined.
    function automatic int t_and(int a, int b);
        if (a == 0 || b == 0) return 0;
        if (a == 1 && b == 1) return 1;
        return 2;
    endfunction
    function automatic int t_or(int a, int b);
        if (a == 1 || b == 1) return 1;
        if (a == 0 && b == 0) return 0;
        return 2;
    endfunction
    function automatic int t_not(int a);
        return (a == 2) ? 2 : 1 - a;
    endfunction
    function automatic int dum_val(int c);
        if (d0[c] != d1[c]) return 2;
        return int'(d0[c]);
    endfunction

    int gv [NG];
    function automatic int src_val(int s, int g);
        if (s < NP) return int'(pi[s]);
        if (s < NP + NC) return dum_val(s - NP);
        if (s - NP - NC < g) return gv[s - NP - NC];
        return 2;
    endfunction

    logic [NC-1:0] exp_c, exp_u;
    logic          exp_w;

    task automatic model();
        for (int g = 0; g < NG; g++) begin
            int a, b, r;
            a = src_val(int'(sa[g]), g);
            b = src_val(int'(sb[g]), g);
            case (op[g])
                3'd0: r = t_and(a, b);
                3'd1: r = t_or(a, b);
                3'd2: r = t_not(t_and(a, b));
                3'd3: r = t_not(t_or(a, b));
                default: r = t_not(a);
            endcase
            gv[g] = r;
        end
        for (int c = 0; c < NC; c++) begin
            if (!cen[c]) begin
                exp_c[c] = 1'b1;
                exp_u[c] = 1'b0;
            end else begin
                exp_c[c] = (dum_val(c) == gv[cg[c]]);
                exp_u[c] = d0[c] ^ d1[c];
            end
        end
        exp_w = (&exp_c) && (|exp_u);
    endtask

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    // Apply current inputs at a falling edge, compare one cycle later.
    task automatic run_vec(string tag);
        model();
        @(posedge clk);
        @(negedge clk);
        check(tag, "consist", int'(cons), int'(exp_c));
        check(tag, "undef", int'(und), int'(exp_u));
        check(tag, "witness", int'(wit), int'(exp_w));
    endtask

    task automatic cfg_clear();
        for (int g = 0; g < NG; g++) begin
            op[g] = 3'd0; sa[g] = 4'd0; sb[g] = 4'd0;
        end
        for (int c = 0; c < NC; c++) cg[c] = 3'd0;
        cen = '0; pi = '0; d0 = '0; d1 = '0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL R9 watchdog act=running exp=finished");
        finish_run();
    end

    initial begin
        cfg_clear();
        cen = '1; d0 = 4'b0101; d1 = 4'b1010;
        repeat (3) @(negedge clk);
        // R9: reset clears every output
        check("R9", "reset consist", int'(cons), 0);
        check("R9", "reset undef", int'(und), 0);
        check("R9", "reset witness", int'(wit), 0);
        rst_n = 1'b1;

        // R10: NAND ring, inputs high, both cuts undefined
        cfg_clear();
        op[0] = 3'd2; sa[0] = 4'd0; sb[0] = 4'd5;
        op[1] = 3'd2; sa[1] = 4'd1; sb[1] = 4'd4;
        cg[0] = 3'd0; cg[1] = 3'd1; cen = 4'b0011;
        pi = 4'b0011; d0 = 4'b0001; d1 = 4'b0010;
        run_vec("R10");
        check("R10", "ring witness", int'(wit), 1);
        check("R10", "ring consist", int'(cons), 4'hF);

        // R5: ring settles definite with input 0 low
        pi = 4'b0010; d0 = 4'b0001; d1 = 4'b0001;
        run_vec("R5");
        check("R5", "settled witness", int'(wit), 0);
        // R5: definite dummies contradicting the gates
        pi = 4'b0011; d0 = 4'b0000; d1 = 4'b0000;
        run_vec("R5");
        check("R5", "mismatch consist0", int'(cons[0]), 0);

        // R2 / R3: op sweep on gate 0, probed through cut 0
        cfg_clear();
        cg[0] = 3'd0; cen = 4'b0001;
        sa[0] = 4'd5; sb[0] = 4'd0;
        for (int o = 0; o < 8; o++) begin
            for (int av = 0; av < 4; av++) begin
                for (int bv = 0; bv < 2; bv++) begin
                    for (int pr = 0; pr < 3; pr++) begin
                        op[0] = 3'(o);
                        d0[1] = av[0]; d1[1] = av[1];
                        pi[0] = bv[0];
                        d0[0] = (pr == 1 || pr == 2);
                        d1[0] = (pr == 1);
                        run_vec(o < 2 ? "R2" : "R3");
                    end
                end
            end
        end

        // R1: primary inputs through a NOT chain
        cfg_clear();
        op[0] = 3'd4; sa[0] = 4'd2;
        op[1] = 3'd7; sa[1] = 4'd8;
        cg[0] = 3'd1; cen = 4'b0001;
        for (int v = 0; v < 2; v++) begin
            pi[2] = v[0]; d0[0] = v[0]; d1[0] = v[0];
            run_vec("R1");
            check("R1", "input passthrough", int'(cons[0]), 1);
        end

        // R4: self and forward references read undefined
        cfg_clear();
        op[0] = 3'd4; sa[0] = 4'd8;
        op[2] = 3'd4; sa[2] = 4'd13;
        op[3] = 3'd1; sa[3] = 4'd0; sb[3] = 4'd9;
        op[1] = 3'd4; sa[1] = 4'd3;
        cg[0] = 3'd0; cg[1] = 3'd2; cg[2] = 3'd3; cen = 4'b0111;
        d0 = 4'b0011; d1 = 4'b0100; pi = 4'b0000;
        run_vec("R4");
        check("R4", "self ref undefined", int'(cons[1:0]), 3);
        pi = 4'b1000;
        run_vec("R4");

        // R8: disabled slots ignore mismatched dummies
        cfg_clear();
        d0 = 4'b1010; d1 = 4'b0110;
        run_vec("R8");
        check("R8", "all disabled witness", int'(wit), 0);
        check("R8", "all disabled undef", int'(und), 0);
        cen = 4'b0100; cg[2] = 3'd5;
        run_vec("R8");

        // R5 / R6 / R7: random configurations
        for (int n = 0; n < 400; n++) begin
            for (int g = 0; g < NG; g++) begin
                op[g] = 3'($urandom_range(0, 7));
                sa[g] = 4'($urandom_range(0, 15));
                sb[g] = 4'($urandom_range(0, 15));
            end
            for (int c = 0; c < NC; c++) cg[c] = 3'($urandom_range(0, 7));
            cen = 4'($urandom); pi = 4'($urandom);
            d0 = 4'($urandom); d1 = 4'($urandom);
            if (n % 3 == 0) d1 = d0;
            run_vec(n % 2 == 0 ? "R6" : "R7");
        end

        // R9: reset mid-run clears outputs
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R9", "rerun reset", int'({cons, und, wit}), 0);
        finish_run();
    end

endmodule